// File: doc/BRIEF.md
# Eight-Instruction Memory-to-Memory CPU

This block is a small microcoded processor that has no register file. Each data instruction takes one or two operands straight from byte-wide memory and writes its result back to memory. It fetches instructions of varying length over a single byte-wide memory port with 16-bit addresses. Its program counter is 15 bits wide, so code can only sit in the lower half of the address space. The core keeps one flag bit, and the flag steers the only conditional branch.

Every instruction takes a fixed frame of micro-steps, 32 by default. A step counter, together with the latched opcode, selects a bundle of strobes for each step: read, write, program-counter increment or load, address-latch loads, operand loads, flag update and the ALU function. Reads are combinational: the read data is taken in the same cycle that the address is driven. A write is committed at the rising clock edge that ends its step.

The address map is fixed. 0000–3FFF is read-only, 4000–7FFF is RAM, 8000–CFFF holds outputs and D000–FFFF holds inputs. The core never asserts a write strobe into the read-only range.

Top module: `cpu8_core`

## Requirements
- R1: While reset is held, and in the first step after it, the core fetches from address 0x0001 with memRd high and memWr low, and the flag is 0.
- R2: Every instruction occupies exactly 32 clock cycles, starting from its fetch, and every opcode fetch happens at an odd address.
- R3: Encoding: the first byte holds the opcode in bits 2:0 (0 STR, 1 MOV, 2 ADD, 3 SUB, 4 NAND, 5 DIV2, 6 JF, 7 JMP). Addresses are stored high byte first. Data instructions are opcode, src(2), dest(2), pad (6 bytes). STR is opcode, constant, dest(2) (4 bytes). Jumps are opcode, target(2), pad (4 bytes).
- R4: MOV copies [src] to [dest] and sets the flag exactly when the value is zero.
- R5: STR writes its constant to [dest] and leaves the flag unchanged.
- R6: ADD writes ([src]+[dest]) mod 256 to dest and puts the carry out in the flag.
- R7: SUB writes ([src]-[dest]) mod 256 to dest and sets the flag when a borrow occurs ([src] < [dest]).
- R8: NAND writes ~([src] & [dest]) to dest and sets the flag exactly when the result is zero.
- R9: DIV2 writes [src] shifted right by one to dest and sets the flag exactly when the result is zero.
- R10: JMP always continues at its target. JF continues at its target when the flag is 1 and at the next instruction otherwise. Neither jump writes memory.
- R11: A write aimed below 0x4000 does not assert memWr, and the read-only contents stay as they were.
- R12: memRd and memWr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 16 | Memory address |
| memRdData | input | 8 | Read data, valid in the same cycle as the address |
| memWrData | output | 8 | Write data |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe, committed at the rising edge |

## Verification
Every ALU instruction is run with operands that set the flag and with operands that clear it. The next instruction is always a JF, so whether the branch is taken shows the flag value through the memory writes that follow. Carry against no carry, borrow against a non-negative result, and zero against nonzero for NAND, DIV2 and MOV each separate a correct flag rule from an inverted or missing one. An STR placed between a flag-setting MOV and a JF checks that stores leave the flag alone. A store aimed at read-only space, followed by a MOV that reads the same location back, shows that the write was dropped. Fetch addresses sampled at 32-cycle boundaries check both the instruction frame length and the byte counts of the instructions.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  typedef enum logic [2:0] {
    OP_STR = 3'd0, OP_MOV = 3'd1, OP_ADD = 3'd2, OP_SUB = 3'd3,
    OP_NAND = 3'd4, OP_HALF = 3'd5, OP_JF = 3'd6, OP_JMP = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_MOVE, ALU_ADD, ALU_SUB, ALU_NAND, ALU_HALF
  } aluop_e;

  typedef struct packed {
    logic   memRd;
    logic   memWr;
    logic   selLatch;
    logic   pcInc;
    logic   pcLoad;
    logic   ldIr;
    logic   ldLatHi;
    logic   ldLatLo;
    logic   ldA;
    logic   ldB;
    logic   flagWr;
    aluop_e aluOp;
  } strobe_t;
endpackage

// File: rtl/cpu8_control.sv
module cpu8_control
  import cpu8_pkg::*;
#(
  parameter int STEPS = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] rdData,
  input  logic          flag,
  output strobe_t       st
);
  localparam int SW = $clog2(STEPS);

  logic [SW-1:0] step;
  opcode_e       ir;
  logic          isData;
  logic          needB;
  logic          taken;
  aluop_e        dataAlu;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0;
      ir   <= OP_JMP;
    end else begin
      step <= (step == SW'(STEPS - 1)) ? '0 : step + 1'b1;
      if (st.ldIr) ir <= opcode_e'(rdData[2:0]);
    end
  end

  always_comb begin
    isData = (ir == OP_MOV) || (ir == OP_ADD) || (ir == OP_SUB) ||
             (ir == OP_NAND) || (ir == OP_HALF);
    needB  = (ir == OP_ADD) || (ir == OP_SUB) || (ir == OP_NAND);
    taken  = (ir == OP_JMP) || flag;
    case (ir)
      OP_MOV:  dataAlu = ALU_MOVE;
      OP_ADD:  dataAlu = ALU_ADD;
      OP_SUB:  dataAlu = ALU_SUB;
      OP_NAND: dataAlu = ALU_NAND;
      OP_HALF: dataAlu = ALU_HALF;
      default: dataAlu = ALU_PASS;
    endcase
  end

  always_comb begin
    st = '0;
    st.aluOp = ALU_PASS;
    if (step == '0) begin
      st.memRd = 1'b1; st.ldIr = 1'b1; st.pcInc = 1'b1;
    end else if (ir == OP_STR) begin
      case (step)
        SW'(1): begin st.memRd = 1'b1; st.ldA = 1'b1; st.pcInc = 1'b1; end
        SW'(2): begin st.memRd = 1'b1; st.ldLatHi = 1'b1; st.pcInc = 1'b1; end
        SW'(3): begin st.memRd = 1'b1; st.ldLatLo = 1'b1; st.pcInc = 1'b1; end
        SW'(4): begin st.selLatch = 1'b1; st.memWr = 1'b1; end
        default: ;
      endcase
    end else if (isData) begin
      case (step)
        SW'(1): begin st.memRd = 1'b1; st.ldLatHi = 1'b1; st.pcInc = 1'b1; end
        SW'(2): begin st.memRd = 1'b1; st.ldLatLo = 1'b1; st.pcInc = 1'b1; end
        SW'(3): begin st.memRd = 1'b1; st.selLatch = 1'b1; st.ldA = 1'b1; end
        SW'(4): begin st.memRd = 1'b1; st.ldLatHi = 1'b1; st.pcInc = 1'b1; end
        SW'(5): begin st.memRd = 1'b1; st.ldLatLo = 1'b1; st.pcInc = 1'b1; end
        SW'(6): begin
          st.memRd = needB; st.selLatch = needB; st.ldB = needB;
        end
        SW'(7): begin
          st.selLatch = 1'b1; st.memWr = 1'b1; st.flagWr = 1'b1;
          st.aluOp = dataAlu; st.pcInc = 1'b1;
        end
        default: ;
      endcase
    end else begin
      case (step)
        SW'(1): begin st.memRd = 1'b1; st.ldLatHi = 1'b1; st.pcInc = 1'b1; end
        SW'(2): begin st.memRd = 1'b1; st.ldLatLo = 1'b1; st.pcInc = 1'b1; end
        SW'(3): begin st.pcLoad = taken; st.pcInc = !taken; end
        default: ;
      endcase
    end
  end

  // R2: the step counter closes each frame after STEPS cycles
  p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (step == SW'(STEPS - 1)) |=> (step == '0));
  // R10: jump instructions never issue a write
  p_jump_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((ir == OP_JF) || (ir == OP_JMP)) |-> !st.memWr);
endmodule

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
  import cpu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int RAM_BASE = 'h4000,
  parameter int RESET_PC = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [DW-1:0] rdData,
  output logic [2*DW-1:0] memAddr,
  output logic [DW-1:0] wrData,
  output logic          memRd,
  output logic          memWr,
  output logic          flag
);
  localparam int AW  = 2 * DW;
  localparam int PCW = AW - 1;

  logic [PCW-1:0] pc;
  logic [AW-1:0]  latch;
  logic [DW-1:0]  a, b, res;
  logic [DW:0]    sum, diff;
  logic           flagNext;

  always_comb begin
    sum      = {1'b0, a} + {1'b0, b};
    diff     = {1'b0, a} - {1'b0, b};
    res      = a;
    flagNext = flag;
    case (st.aluOp)
      ALU_MOVE: flagNext = (a == '0);
      ALU_ADD:  begin res = sum[DW-1:0];  flagNext = sum[DW]; end
      ALU_SUB:  begin res = diff[DW-1:0]; flagNext = diff[DW]; end
      ALU_NAND: begin res = ~(a & b); flagNext = ((a & b) == '1); end
      ALU_HALF: begin res = a >> 1; flagNext = (a[DW-1:1] == '0); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= PCW'(RESET_PC);
      latch <= '0;
      a     <= '0;
      b     <= '0;
      flag  <= 1'b0;
    end else begin
      if (st.pcLoad)     pc <= latch[PCW-1:0];
      else if (st.pcInc) pc <= pc + 1'b1;
      if (st.ldLatHi) latch[AW-1:DW] <= rdData;
      if (st.ldLatLo) latch[DW-1:0]  <= rdData;
      if (st.ldA) a <= rdData;
      if (st.ldB) b <= rdData;
      if (st.flagWr) flag <= flagNext;
    end
  end

  assign memAddr = st.selLatch ? latch : {1'b0, pc};
  assign wrData  = res;
  assign memRd   = st.memRd;
  assign memWr   = st.memWr && (memAddr >= AW'(RAM_BASE));

  // R2: opcode fetches only from odd addresses
  p_fetch_odd_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.ldIr |-> memAddr[0]);
  // R5: flag only moves on a flag-writing step
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.flagWr |=> $stable(flag));
  // R3: sequential operand walk advances the counter by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.pcInc && !st.pcLoad) |=> (pc == $past(pc) + 1'b1));
  // R10: a taken jump lands on the latched target
  p_jump_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.pcLoad |=> (pc == $past(latch[PCW-1:0])));
  // R12: never read and write together
  p_rd_wr_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic [15:0] memAddr,
  input  logic [7:0]  memRdData,
  output logic [7:0]  memWrData,
  output logic        memRd,
  output logic        memWr
);
  strobe_t st;
  logic    flag;

  cpu8_control #(.STEPS(32), .DW(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdData(memRdData), .flag(flag), .st(st)
  );

  cpu8_datapath #(.DW(8), .RAM_BASE('h4000), .RESET_PC(1)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .rdData(memRdData),
    .memAddr(memAddr), .wrData(memWrData), .memRd(memRd),
    .memWr(memWr), .flag(flag)
  );
endmodule

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] memAddr;
  logic [7:0]  memRdData, memWrData;
  logic memRd, memWr;

  logic [7:0] rom [256];
  logic [7:0] ram [256];
  int romWrites = 0;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int pcB;

  always #2.5 clk = ~clk;

  cpu8_core uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdData(memRdData),
    .memWrData(memWrData), .memRd(memRd), .memWr(memWr)
  );

  assign memRdData = (memAddr < 16'h4000) ? rom[memAddr[7:0]] : ram[memAddr[7:0]];

  always @(posedge clk) begin
    if (memWr) begin
      if (memAddr < 16'h4000) romWrites++;
      else ram[memAddr[7:0]] <= memWrData;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, cycles %0d expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) begin rom[i] = 8'h00; ram[i] = 8'h00; end
    romWrites = 0;
    pcB = 1;
  endtask

  task automatic putB(input logic [7:0] v);
    rom[pcB[7:0]] = v;
    pcB++;
  endtask

  task automatic emitStr(input logic [7:0] c, input logic [15:0] dst);
    putB(8'd0); putB(c); putB(dst[15:8]); putB(dst[7:0]);
  endtask

  task automatic emitOp(input logic [7:0] op, input logic [15:0] src, input logic [15:0] dst);
    putB(op); putB(src[15:8]); putB(src[7:0]); putB(dst[15:8]); putB(dst[7:0]); putB(8'h00);
  endtask

  task automatic emitJ(input logic [7:0] op, input int tgt);
    putB(op); putB(8'(tgt >> 8)); putB(8'(tgt)); putB(8'h00);
  endtask

  task automatic runProg(input int nInstr);
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    repeat (nInstr * 32) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    clearMem();
    emitStr(8'h5A, 16'h4000);
    emitJ(8'd7, pcB);
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fetch address in reset", memAddr, 16'h0001);
    chk("R1 memRd in reset", memRd, 1);
    chk("R1 memWr in reset", memWr, 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R3 operand address after fetch", memAddr, 16'h0002);
    repeat (31) @(posedge clk);
    @(negedge clk);
    chk("R2 second fetch at cycle 32", memAddr, 16'h0005);
    chk("R2 second fetch strobe", memRd, 1);
    chk("R5 STR constant stored", ram[8'h00], 8'h5A);
    repeat (64) @(posedge clk);
    @(negedge clk);
    chk("R10 JMP to itself", memAddr, 16'h0005);
  endtask

  task automatic tStrMov();
    clearMem();
    emitStr(8'h99, 16'h4001);
    emitStr(8'h00, 16'h4000);
    emitOp(8'd1, 16'h4000, 16'h4001);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h11, 16'h4002);
    emitStr(8'h22, 16'h4003);
    emitOp(8'd1, 16'h4003, 16'h4004);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h33, 16'h4005);
    emitOp(8'd1, 16'h4000, 16'h4006);
    emitStr(8'h44, 16'h4007);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h55, 16'h4008);
    emitJ(8'd7, pcB);
    runProg(20);
    chk("R4 MOV copies zero", ram[8'h01], 8'h00);
    chk("R4 MOV zero sets flag, JF taken", ram[8'h02], 8'h00);
    chk("R4 MOV copies nonzero", ram[8'h04], 8'h22);
    chk("R4 MOV nonzero clears flag, JF falls through", ram[8'h05], 8'h33);
    chk("R5 STR keeps flag, JF taken", ram[8'h08], 8'h00);
    chk("R5 STR store", ram[8'h07], 8'h44);
  endtask

  task automatic tAdd();
    clearMem();
    emitStr(8'hF0, 16'h4010);
    emitStr(8'h20, 16'h4011);
    emitOp(8'd2, 16'h4010, 16'h4011);
    emitJ(8'd6, pcB + 8);
    emitStr(8'hEE, 16'h4012);
    emitStr(8'h01, 16'h4013);
    emitOp(8'd2, 16'h4013, 16'h4013);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h55, 16'h4014);
    emitJ(8'd7, pcB);
    runProg(16);
    chk("R6 ADD wraps", ram[8'h11], 8'h10);
    chk("R6 ADD carry sets flag", ram[8'h12], 8'h00);
    chk("R6 ADD sum", ram[8'h13], 8'h02);
    chk("R6 ADD no carry clears flag", ram[8'h14], 8'h55);
  endtask

  task automatic tSub();
    clearMem();
    emitStr(8'h30, 16'h4020);
    emitStr(8'h10, 16'h4021);
    emitOp(8'd3, 16'h4020, 16'h4021);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h66, 16'h4022);
    emitOp(8'd3, 16'h4021, 16'h4020);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h77, 16'h4023);
    emitJ(8'd7, pcB);
    runProg(14);
    chk("R7 SUB difference", ram[8'h21], 8'h20);
    chk("R7 SUB no borrow, JF falls through", ram[8'h22], 8'h66);
    chk("R7 SUB wraps on borrow", ram[8'h20], 8'hF0);
    chk("R7 SUB borrow sets flag", ram[8'h23], 8'h00);
  endtask

  task automatic tNandHalf();
    clearMem();
    emitStr(8'hFF, 16'h4030);
    emitStr(8'hFF, 16'h4031);
    emitOp(8'd4, 16'h4030, 16'h4031);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h12, 16'h4032);
    emitStr(8'h81, 16'h4033);
    emitOp(8'd5, 16'h4033, 16'h4034);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h34, 16'h4035);
    emitStr(8'h01, 16'h4037);
    emitStr(8'h77, 16'h4038);
    emitOp(8'd5, 16'h4037, 16'h4038);
    emitJ(8'd6, pcB + 8);
    emitStr(8'h56, 16'h4039);
    emitStr(8'h0F, 16'h403A);
    emitStr(8'hF0, 16'h403B);
    emitOp(8'd4, 16'h403A, 16'h403B);
    emitJ(8'd7, pcB);
    runProg(26);
    chk("R8 NAND result zero", ram[8'h31], 8'h00);
    chk("R8 NAND zero sets flag", ram[8'h32], 8'h00);
    chk("R8 NAND nonzero result", ram[8'h3B], 8'hFF);
    chk("R9 DIV2 result", ram[8'h34], 8'h40);
    chk("R9 DIV2 nonzero clears flag", ram[8'h35], 8'h34);
    chk("R9 DIV2 of one gives zero", ram[8'h38], 8'h00);
    chk("R9 DIV2 zero sets flag", ram[8'h39], 8'h00);
  endtask

  task automatic tRomWrite();
    clearMem();
    rom[8'hC0] = 8'hA5;
    emitStr(8'h77, 16'h00C0);
    emitOp(8'd1, 16'h00C0, 16'h4040);
    emitJ(8'd7, pcB);
    runProg(6);
    chk("R11 no write strobe into read-only range", romWrites, 0);
    chk("R11 read-only byte unchanged", ram[8'h40], 8'hA5);
  endtask

  task automatic tJumps();
    clearMem();
    emitJ(8'd6, pcB + 8);
    emitStr(8'h33, 16'h4052);
    emitJ(8'd7, pcB + 8);
    emitStr(8'h11, 16'h4050);
    emitStr(8'h22, 16'h4051);
    emitJ(8'd7, pcB);
    runProg(10);
    chk("R10 JF with flag 0 falls through", ram[8'h52], 8'h33);
    chk("R10 JMP skips", ram[8'h50], 8'h00);
    chk("R10 JMP target runs", ram[8'h51], 8'h22);
    chk("R12 idle loop never writes", memWr, 0);
  endtask

  initial begin
    tReset();
    tStrMov();
    tAdd();
    tSub();
    tNandHalf();
    tRomWrite();
    tJumps();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule